// File: doc/BRIEF.md
# Single-Pin Serial Frame Engine

This block is the device-side half of a serial link that carries both timing and data over one bidirectional wire. The wire is open-drain with a pull-up, so the engine can only pull it low or let it float high. It takes its time base from the slow internal clock used in programming mode. It repeats a fixed frame of 17 bit-cycles, and each bit-cycle lasts four clocks.

Every frame opens with a sync cycle. In that cycle the engine pulls the wire low for two clocks and then releases it, which gives the external programmer a falling edge to lock onto. Four command cycles follow, in which the programmer sends a 4-bit command, most significant bit first. Twelve data cycles close the frame. In those the word travels either toward the device or away from it, as chosen by a direction input that is captured once the command has arrived. Downstream logic reads the received command and data word and acts on them. Frames run back to back for as long as the enable input stays high.

Top module: `pin_frame_engine`

## Requirements
- R1: While reset is asserted, `pin_pull_o`, `frame_done_o`, `cmd_o` and `rx_data_o` are all zero.
- R2: With `enable_i` held high, frames repeat without gaps. `frame_done_o` pulses once every 68 clocks (17 cycles of 4 clocks).
- R3: Cycle 0 of each frame is sync. `pin_pull_o` is 1 for its first two clocks and 0 for its last two.
- R4: The engine samples the wire once per cycle, at the edge that ends the third clock of the cycle. The wire level in the other three clocks has no effect.
- R5: Cycles 1 to 4 carry the command with the first cycle as bit 3. `cmd_o` takes the new value at the end of cycle 4 and keeps it until the next frame's command completes.
- R6: `data_dir_i` (0 = receive, 1 = transmit) and `tx_data_i` are captured at the edge that ends cycle 4. Changing them later in the frame has no effect on that frame.
- R7: In a receive frame, cycles 5 to 16 deliver a 12-bit word, first cycle as bit 11. `rx_data_o` takes this word in the same clock in which `frame_done_o` is high.
- R8: In a transmit frame, data cycle n (n = 5..16) carries bit 16-n of the captured word. `pin_pull_o` is 1 for the whole cycle when that bit is 0 and 0 when it is 1. `rx_data_o` does not change in a transmit frame.
- R9: `pin_pull_o` is never 1 in command cycles or in receive data cycles.
- R10: When `enable_i` is low, the next clock leaves `pin_pull_o` and `frame_done_o` at 0 and clears the frame position. An interrupted frame neither pulses `frame_done_o` nor updates `rx_data_o`. When `enable_i` returns high, a new frame starts with sync one clock later.
- R11: `frame_done_o` is high for exactly one clock, and that clock is the first clock of the next frame's sync cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal programming-mode clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs frames while high; idles with the wire released while low |
| data_dir_i | input | 1 | Data direction for the current frame: 0 receive, 1 transmit |
| tx_data_i | input | 12 | Word to transmit in a transmit frame |
| pin_i | input | 1 | Level sensed on the shared wire |
| pin_pull_o | output | 1 | Open-drain drive enable: 1 pulls the wire low |
| cmd_o | output | 4 | Most recently received command |
| rx_data_o | output | 12 | Most recently received data word |
| frame_done_o | output | 1 | One-clock pulse at the end of each complete frame |

## Verification
The bound checker enforces the following on every clock:
- `frame_done_o` is a single-clock pulse that falls on the low half of sync.
- The wire is released in the second half of sync and during the command cycles.
- Disabling releases the wire on the next clock.
- `cmd_o` changes only on the edge that closes the command field.
- `rx_data_o` changes only together with `frame_done_o`.

Some properties need a model of the programmer's side of the wire, so only the bench scenarios show them:
- MSB-first assembly of commands and words.
- Sampling on the third clock. The bench drives the complement of each bit outside that clock.
- The bit pattern pulled out in transmit frames.
- That direction and transmit word are held from the end of the command.
- That an aborted frame leaves the data word alone.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

  typedef enum logic [1:0] {
    FLD_IDLE = 2'd0,
    FLD_SYNC = 2'd1,
    FLD_CMD  = 2'd2,
    FLD_DATA = 2'd3
  } field_e;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

endpackage

// File: rtl/pfe_timer.sv
// Frame position: phase within a cycle, cycle within a frame, and strobes.
module pfe_timer
  import pfe_pkg::*;
#(
  parameter int CLKS_PER_CYCLE = 4,
  parameter int CMD_BITS       = 4,
  parameter int DATA_BITS      = 12,
  parameter int SAMPLE_PHASE   = 2,
  localparam int FRAME_CYCLES  = 1 + CMD_BITS + DATA_BITS,
  localparam int PHASE_W       = $clog2(CLKS_PER_CYCLE),
  localparam int CYC_W         = $clog2(FRAME_CYCLES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [CYC_W-1:0]   cycle_o,
  output field_e             field_o,
  output logic               sample_o,
  output logic               cycle_end_o,
  output logic               cmd_end_o,
  output logic               frame_end_o
);

  localparam logic [PHASE_W-1:0] PH_LAST   = PHASE_W'(CLKS_PER_CYCLE - 1);
  localparam logic [PHASE_W-1:0] PH_SAMPLE = PHASE_W'(SAMPLE_PHASE);
  localparam logic [CYC_W-1:0]   CYC_CMD_L = CYC_W'(CMD_BITS);
  localparam logic [CYC_W-1:0]   CYC_LAST  = CYC_W'(FRAME_CYCLES - 1);

  logic               active_q;
  logic [PHASE_W-1:0] phase_q;
  logic [CYC_W-1:0]   cycle_q;
  logic               run;

  assign run = active_q & enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      cycle_q  <= '0;
    end else if (!enable_i) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      cycle_q  <= '0;
    end else begin
      active_q <= 1'b1;
      if (active_q) begin
        if (phase_q == PH_LAST) begin
          phase_q <= '0;
          cycle_q <= (cycle_q == CYC_LAST) ? '0 : cycle_q + 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!active_q)               field_o = FLD_IDLE;
    else if (cycle_q == '0)      field_o = FLD_SYNC;
    else if (cycle_q <= CYC_CMD_L) field_o = FLD_CMD;
    else                         field_o = FLD_DATA;
  end

  assign phase_o     = phase_q;
  assign cycle_o     = cycle_q;
  assign sample_o    = run & (phase_q == PH_SAMPLE);
  assign cycle_end_o = run & (phase_q == PH_LAST);
  assign cmd_end_o   = cycle_end_o & (cycle_q == CYC_CMD_L);
  assign frame_end_o = cycle_end_o & (cycle_q == CYC_LAST);

endmodule

// File: rtl/pfe_shift_in.sv
// Serial-in, parallel-out capture register, first bit ends up as MSB.
module pfe_shift_in #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[WIDTH-2:0], bit_i};
  end

  assign q_o = sh_q;

endmodule

// File: rtl/pfe_shift_out.sv
// Parallel-in, serial-out register, MSB presented first.
module pfe_shift_out #(
  parameter int WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_i,
  output logic             bit_o
);

  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[WIDTH-2:0], 1'b1};
  end

  assign bit_o = sh_q[WIDTH-1];

endmodule

// File: rtl/pfe_pin_ctrl.sv
// Open-drain drive decision: sync low pulse, or transmit zeros.
module pfe_pin_ctrl
  import pfe_pkg::*;
#(
  parameter int CLKS_PER_CYCLE = 4,
  parameter int SYNC_LOW_CLKS  = 2,
  localparam int PHASE_W       = $clog2(CLKS_PER_CYCLE)
) (
  input  field_e             field_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  dir_e               dir_i,
  input  logic               tx_bit_i,
  output logic               pull_o
);

  localparam logic [PHASE_W-1:0] PH_SYNC_END = PHASE_W'(SYNC_LOW_CLKS);

  logic sync_low;
  logic tx_low;

  assign sync_low = (field_i == FLD_SYNC) & (phase_i < PH_SYNC_END);
  assign tx_low   = (field_i == FLD_DATA) & (dir_i == DIR_TX) & ~tx_bit_i;
  assign pull_o   = sync_low | tx_low;

endmodule

// File: rtl/pin_frame_engine.sv
module pin_frame_engine
  import pfe_pkg::*;
#(
  parameter int CLKS_PER_CYCLE = 4,
  parameter int CMD_BITS       = 4,
  parameter int DATA_BITS      = 12,
  parameter int SAMPLE_PHASE   = 2,
  parameter int SYNC_LOW_CLKS  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enable_i,
  input  logic                 data_dir_i,
  input  logic [DATA_BITS-1:0] tx_data_i,
  input  logic                 pin_i,
  output logic                 pin_pull_o,
  output logic [CMD_BITS-1:0]  cmd_o,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 frame_done_o
);

  localparam int FRAME_CYCLES = 1 + CMD_BITS + DATA_BITS;
  localparam int PHASE_W      = $clog2(CLKS_PER_CYCLE);
  localparam int CYC_W        = $clog2(FRAME_CYCLES);

  logic [PHASE_W-1:0]   phase_w;
  logic [CYC_W-1:0]     cycle_w;
  field_e               field_w;
  logic                 sample_w;
  logic                 cycle_end_w;
  logic                 cmd_end_w;
  logic                 frame_end_w;
  logic [CMD_BITS-1:0]  cmd_sr_w;
  logic [DATA_BITS-1:0] rx_sr_w;
  logic                 tx_bit_w;
  dir_e                 dir_q;
  logic [CMD_BITS-1:0]  cmd_q;
  logic [DATA_BITS-1:0] rx_q;
  logic                 done_q;

  pfe_timer #(
    .CLKS_PER_CYCLE(CLKS_PER_CYCLE),
    .CMD_BITS      (CMD_BITS),
    .DATA_BITS     (DATA_BITS),
    .SAMPLE_PHASE  (SAMPLE_PHASE)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .phase_o    (phase_w),
    .cycle_o    (cycle_w),
    .field_o    (field_w),
    .sample_o   (sample_w),
    .cycle_end_o(cycle_end_w),
    .cmd_end_o  (cmd_end_w),
    .frame_end_o(frame_end_w)
  );

  pfe_shift_in #(.WIDTH(CMD_BITS)) u_cmd_sr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (sample_w & (field_w == FLD_CMD)),
    .bit_i (pin_i),
    .q_o   (cmd_sr_w)
  );

  pfe_shift_in #(.WIDTH(DATA_BITS)) u_rx_sr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (sample_w & (field_w == FLD_DATA)),
    .bit_i (pin_i),
    .q_o   (rx_sr_w)
  );

  pfe_shift_out #(.WIDTH(DATA_BITS)) u_tx_sr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmd_end_w),
    .data_i (tx_data_i),
    .shift_i(cycle_end_w & (field_w == FLD_DATA)),
    .bit_o  (tx_bit_w)
  );

  pfe_pin_ctrl #(
    .CLKS_PER_CYCLE(CLKS_PER_CYCLE),
    .SYNC_LOW_CLKS (SYNC_LOW_CLKS)
  ) u_pin (
    .field_i (field_w),
    .phase_i (phase_w),
    .dir_i   (dir_q),
    .tx_bit_i(tx_bit_w),
    .pull_o  (pin_pull_o)
  );

  // Direction and command are frozen once the command field closes.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_RX;
      cmd_q <= '0;
    end else if (cmd_end_w) begin
      dir_q <= dir_e'(data_dir_i);
      cmd_q <= cmd_sr_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= frame_end_w;
      if (frame_end_w && dir_q == DIR_RX) rx_q <= rx_sr_w;
    end
  end

  assign cmd_o        = cmd_q;
  assign rx_data_o    = rx_q;
  assign frame_done_o = done_q;

endmodule

// File: rtl/pfe_checker.sv
module pfe_checker #(
  parameter int CLKS_PER_CYCLE = 4,
  parameter int CMD_BITS       = 4,
  parameter int DATA_BITS      = 12,
  parameter int SYNC_LOW_CLKS  = 2,
  localparam int FRAME_CYCLES  = 1 + CMD_BITS + DATA_BITS,
  localparam int PHASE_W       = $clog2(CLKS_PER_CYCLE),
  localparam int CYC_W         = $clog2(FRAME_CYCLES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 enable_i,
  input logic                 pin_pull_o,
  input logic                 frame_done_o,
  input logic [CMD_BITS-1:0]  cmd_o,
  input logic [DATA_BITS-1:0] rx_data_o,
  input logic [PHASE_W-1:0]   phase_i,
  input logic [CYC_W-1:0]     cycle_i
);

  localparam logic [PHASE_W-1:0] PH_LAST   = PHASE_W'(CLKS_PER_CYCLE - 1);
  localparam logic [PHASE_W-1:0] PH_SYNC_E = PHASE_W'(SYNC_LOW_CLKS);
  localparam logic [CYC_W-1:0]   CYC_CMD_L = CYC_W'(CMD_BITS);

  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  assert_done_in_sync_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> pin_pull_o);

  assert_sync_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_i == '0 && phase_i >= PH_SYNC_E) |-> !pin_pull_o);

  assert_cmd_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_i != '0 && cycle_i <= CYC_CMD_L) |-> !pin_pull_o);

  assert_disable_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!pin_pull_o && !frame_done_o));

  assert_cmd_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> $past(enable_i && cycle_i == CYC_CMD_L && phase_i == PH_LAST));

  assert_rx_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> frame_done_o);

endmodule

bind pin_frame_engine pfe_checker #(
  .CLKS_PER_CYCLE(CLKS_PER_CYCLE),
  .CMD_BITS      (CMD_BITS),
  .DATA_BITS     (DATA_BITS),
  .SYNC_LOW_CLKS (SYNC_LOW_CLKS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .pin_pull_o  (pin_pull_o),
  .frame_done_o(frame_done_o),
  .cmd_o       (cmd_o),
  .rx_data_o   (rx_data_o),
  .phase_i     (phase_w),
  .cycle_i     (cycle_w)
);

// File: tb/pin_frame_engine_test.sv
module pin_frame_engine_test;

  localparam int FRAME_CLKS = 68;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [11:0] rx;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        data_dir = 1'b0;
  logic [11:0] tx_data = '0;
  logic        host_pull = 1'b0;
  logic        pin;
  logic        pin_pull;
  logic [3:0]  cmd;
  logic [11:0] rx_data;
  logic        frame_done;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   finished = 1'b0;
  exp_t sb_q[$];
  logic [11:0] exp_rx = '0;

  always #4 clk = ~clk;

  assign pin = ~(pin_pull | host_pull);

  pin_frame_engine uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .enable_i    (enable),
    .data_dir_i  (data_dir),
    .tx_data_i   (tx_data),
    .pin_i       (pin),
    .pin_pull_o  (pin_pull),
    .cmd_o       (cmd),
    .rx_data_o   (rx_data),
    .frame_done_o(frame_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Programmer model: one call walks one frame from the negedge at index 0.
  task automatic run_frame(input logic [3:0] c, input bit dir,
                           input logic [11:0] d, input int stop);
    for (int p = 0; p < stop; p++) begin
      int cyc = p / 4;
      int ph  = p % 4;
      logic b;
      b = 1'b1;
      host_pull = 1'b0;
      if (cyc >= 1 && cyc <= 4) b = c[4 - cyc];
      if (cyc >= 5 && dir == 1'b0) b = d[16 - cyc];
      // bit value only in the sampling clock, complement elsewhere (R4)
      if ((cyc >= 1 && cyc <= 4) || (cyc >= 5 && dir == 1'b0))
        host_pull = (ph == 2) ? ~b : b;
      if (p == 8) begin
        data_dir = dir;
        tx_data  = d;
      end
      if (p == 24) begin
        data_dir = ~dir;
        tx_data  = ~d;
      end
      if (cyc == 0)
        check(pin_pull == (ph < 2), "R3 sync pull", {31'd0, pin_pull}, {31'd0, ph < 2});
      if (p == 1)
        check(frame_done == 1'b0, "R11 pulse width", {31'd0, frame_done}, 32'd0);
      if (cyc >= 1 && ph == 3 && (cyc <= 4 || dir == 1'b0))
        check(pin_pull == 1'b0, "R9 no pull", {31'd0, pin_pull}, 32'd0);
      if (cyc >= 5 && dir == 1'b1 && ph == 1)
        check(pin_pull == ~d[16 - cyc], "R8 R6 tx bit", {31'd0, pin_pull},
              {31'd0, ~d[16 - cyc]});
      if (p == 20) begin
        check(cmd == c, "R5 R4 cmd latch", {28'd0, cmd}, {28'd0, c});
        if (dir == 1'b0 && stop == FRAME_CLKS) exp_rx = d;
        if (stop == FRAME_CLKS) sb_q.push_back('{cmd: c, rx: exp_rx});
      end
      if (dir == 1'b1 && p == 60)
        check(rx_data == exp_rx, "R8 rx held", {20'd0, rx_data}, {20'd0, exp_rx});
      @(negedge clk);
    end
    host_pull = 1'b0;
  endtask

  // Monitor: pops the scoreboard on each frame end.
  int clk_cnt = 0;
  int last_done = 0;
  bit prev_valid = 1'b0;
  always @(negedge clk) begin
    clk_cnt++;
    if (!enable) prev_valid = 1'b0;
    if (frame_done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected frame_done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(cmd == e.cmd, "R5 cmd at done", {28'd0, cmd}, {28'd0, e.cmd});
        check(rx_data == e.rx, "R7 R6 rx word", {20'd0, rx_data}, {20'd0, e.rx});
      end
      if (prev_valid)
        check(clk_cnt - last_done == FRAME_CLKS, "R2 frame period",
              clk_cnt - last_done, FRAME_CLKS);
      last_done  = clk_cnt;
      prev_valid = 1'b1;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pin_pull == 1'b0 && frame_done == 1'b0, "R1 reset outputs",
          {30'd0, pin_pull, frame_done}, 32'd0);
    check(cmd == 4'd0 && rx_data == 12'd0, "R1 reset regs", {16'd0, cmd, rx_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(pin_pull == 1'b1, "R10 start with sync", {31'd0, pin_pull}, 32'd1);

    run_frame(4'hA, 1'b0, 12'hA5C, FRAME_CLKS);
    run_frame(4'h5, 1'b1, 12'h3C1, FRAME_CLKS);
    run_frame(4'hF, 1'b0, 12'hFFF, FRAME_CLKS);
    run_frame(4'h0, 1'b0, 12'h000, FRAME_CLKS);
    run_frame(4'h9, 1'b1, 12'h800, FRAME_CLKS);
    run_frame(4'h6, 1'b0, 12'h123, FRAME_CLKS);
    // abort in the data field
    run_frame(4'hC, 1'b0, 12'h5AA, 40);
    enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      check(pin_pull == 1'b0 && frame_done == 1'b0, "R10 idle released",
            {30'd0, pin_pull, frame_done}, 32'd0);
      @(negedge clk);
    end
    check(rx_data == exp_rx, "R10 rx untouched", {20'd0, rx_data}, {20'd0, exp_rx});
    check(cmd == 4'hC, "R10 cmd held", {28'd0, cmd}, 32'hC);
    enable = 1'b1;
    @(negedge clk);
    check(pin_pull == 1'b1, "R10 restart sync", {31'd0, pin_pull}, 32'd1);
    run_frame(4'h3, 1'b0, 12'h9E7, FRAME_CLKS);
    run_frame(4'h1, 1'b1, 12'hFFE, FRAME_CLKS);
    run_frame(4'hE, 1'b0, 12'h001, FRAME_CLKS);
    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "R2 all frames done", sb_q.size(), 32'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R2 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule